// File: doc/BRIEF.md
# Chained Vector Multiply-Add Pair

This block holds two pipelined integer vector units and the vector storage they work on. A single start command runs a fixed pair of operations over a shared element count: first a multiply that forms a product vector from two source vectors, then an add that combines that product vector with a third source vector into a result vector. Elements are 32-bit integers. The product keeps only its low 32 bits, and the sum wraps modulo 2^32.

The add depends on the multiply's output vector. With chaining on, each product element is forwarded to the adder as soon as it is written. A per-element ready bit on the product vector gates each adder issue, so the adder never reads an element before it exists. With chaining off, the adder waits until the whole product vector is written, which gives a baseline for comparison. The multiplier has six stages and the adder has two. Both accept one element per cycle.

The storage holds five vectors and is reached through a test port. The port loads a word at a time and reads any element back combinationally. Software loads the sources, pulses start, waits for the one-cycle completion pulse, and then reads the results.

Top module: `vchain_top`

## Requirements
- R1: After a synchronous active-low reset, `busy_o` and `done_o` are both low.
- R2: While `busy_o` is low, `ld_en_i` writes `ld_data_i` into element `ld_idx_i` of the vector picked by `ld_sel_i`. The encoding is 0 product, 1 multiply source A, 2 multiply source B, 3 sum, 4 add source. `rd_data_o` shows element `rd_idx_i` of the vector picked by `rd_sel_i` in the same cycle. Selects 5 to 7 read as zero, and a write to them changes nothing.
- R3: For every element i below the effective length, product[i] becomes the low 32 bits of A[i]*B[i].
- R4: For every element i below the effective length, sum[i] becomes product[i] + addsrc[i] modulo 2^32.
- R5: Product and sum elements at or above the effective length keep their old contents.
- R6: With `chain_en_i` high, `done_o` is high after the (L+8)-th rising edge that follows the edge sampling `start_i`, where L is the effective length (L of at least 1).
- R7: With `chain_en_i` low, `done_o` is high after the (2L+7)-th such edge (L of at least 1).
- R8: A length of zero writes nothing and raises `done_o` after the first edge following the start.
- R9: The effective length is `vl_i` clamped to the vector capacity MVL (default 32).
- R10: While `busy_o` is high, `start_i` and `ld_en_i` are ignored. The running length, the mode and the stored data are unaffected.
- R11: `done_o` is a one-cycle pulse. `busy_o` is high from the edge after the start until the edge where `done_o` rises.
- R12: With chaining on, sum[0] holds its new value after the 8th edge following the start, while the multiply is still running. With chaining off and L=32, sum[0] still holds its old value at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start the multiply-then-add pair |
| vl_i | input | 6 | Requested element count |
| chain_en_i | input | 1 | 1 forwards per element, 0 waits for the full product |
| ld_en_i | input | 1 | Test write enable |
| ld_sel_i | input | 3 | Test write vector select |
| ld_idx_i | input | 5 | Test write element index |
| ld_data_i | input | 32 | Test write data |
| rd_sel_i | input | 3 | Test read vector select |
| rd_idx_i | input | 5 | Test read element index |
| rd_data_o | output | 32 | Test read data (combinational) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The completion pulse is due L+8 edges after the start edge in chained mode, 2L+7 edges after it in unchained mode, and one edge after it for a zero length. The bench counts edges from the start edge and samples `done_o` at each falling edge, so a pulse that comes one cycle early or late is caught. The bench sweeps every length from 0 to 34 in both modes. At edge 8 of the full-length runs it reads sum[0] through the test port, where chained and unchained results must differ. All product and sum elements are read back only after the completion pulse.

// File: rtl/vchain_pkg.sv
// Shared constants for the chained vector multiply-add pair.
// Assumes five vectors addressed by a 3-bit select.
package vchain_pkg;
    localparam int unsigned NUM_VREGS = 5;

    typedef enum logic [2:0] {
        VR_PROD = 3'd0,
        VR_MULA = 3'd1,
        VR_MULB = 3'd2,
        VR_SUM  = 3'd3,
        VR_ADDB = 3'd4
    } vreg_e;
endpackage

// File: rtl/vchain_pipe.sv
// Element pipeline: computes x*y (MULT=1) or x+y (MULT=0) and carries valid
// and element index through STAGES-1 registers; the register file write
// that follows forms the last stage. Assumes STAGES >= 2.
module vchain_pipe #(
    parameter int unsigned DW     = 32,
    parameter int unsigned IW     = 5,
    parameter int unsigned STAGES = 6,
    parameter bit          MULT   = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [IW-1:0] in_idx,
    input  logic [DW-1:0] in_x,
    input  logic [DW-1:0] in_y,
    output logic          out_valid,
    output logic [IW-1:0] out_idx,
    output logic [DW-1:0] out_data
);
    localparam int unsigned REGS = STAGES - 1;

    logic [DW-1:0] res;
    logic          vld [REGS];
    logic [IW-1:0] idx [REGS];
    logic [DW-1:0] dat [REGS];

    generate
        if (MULT) begin : g_mul
            assign res = in_x * in_y;
        end else begin : g_add
            assign res = in_x + in_y;
        end
    endgenerate

    // First register: capture the operation result with its tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld[0] <= 1'b0;
        end else begin
            vld[0] <= in_valid;
            idx[0] <= in_idx;
            dat[0] <= res;
        end
    end

    generate
        for (genvar s = 1; s < REGS; s++) begin : g_stage
            // Shift one element one stage further.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld[s] <= 1'b0;
                end else begin
                    vld[s] <= vld[s-1];
                    idx[s] <= idx[s-1];
                    dat[s] <= dat[s-1];
                end
            end
        end
    endgenerate

    assign out_valid = vld[REGS-1];
    assign out_idx   = idx[REGS-1];
    assign out_data  = dat[REGS-1];
endmodule

// File: rtl/vchain_vrf.sv
// Five-vector element storage: one test write, product and sum write ports,
// two read pairs for the units and one test read. Storage is not reset.
// Assumes test writes never coincide with unit writes (top blocks them).
module vchain_vrf
    import vchain_pkg::*;
#(
    parameter int unsigned DW  = 32,
    parameter int unsigned MVL = 32,
    parameter int unsigned IW  = 5
) (
    input  logic          clk,
    input  logic          ld_we,
    input  logic [2:0]    ld_sel,
    input  logic [IW-1:0] ld_idx,
    input  logic [DW-1:0] ld_data,
    input  logic          pw_en,
    input  logic [IW-1:0] pw_idx,
    input  logic [DW-1:0] pw_data,
    input  logic          sw_en,
    input  logic [IW-1:0] sw_idx,
    input  logic [DW-1:0] sw_data,
    input  logic [IW-1:0] mul_idx,
    output logic [DW-1:0] mul_a,
    output logic [DW-1:0] mul_b,
    input  logic [IW-1:0] add_idx,
    output logic [DW-1:0] add_p,
    output logic [DW-1:0] add_b,
    input  logic [2:0]    rd_sel,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [NUM_VREGS][MVL];

    // Apply test, product and sum writes.
    always_ff @(posedge clk) begin
        if (ld_we && (ld_sel < 3'(NUM_VREGS)))
            mem[ld_sel][ld_idx] <= ld_data;
        if (pw_en)
            mem[VR_PROD][pw_idx] <= pw_data;
        if (sw_en)
            mem[VR_SUM][sw_idx] <= sw_data;
    end

    assign mul_a = mem[VR_MULA][mul_idx];
    assign mul_b = mem[VR_MULB][mul_idx];
    assign add_p = mem[VR_PROD][add_idx];
    assign add_b = mem[VR_ADDB][add_idx];

    // Test read: unused selects return zero.
    always_comb begin
        rd_data = '0;
        if (rd_sel < 3'(NUM_VREGS))
            rd_data = mem[rd_sel][rd_idx];
    end
endmodule

// File: rtl/vchain_seq.sv
// Sequencer: latches the length and mode, issues multiply elements one per
// cycle, tracks per-element product readiness and gates adder issue on it,
// and signals completion once every sum is written.
module vchain_seq #(
    parameter int unsigned MVL = 32,
    parameter int unsigned IW  = 5,
    parameter int unsigned LW  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] vl,
    input  logic          chain_en,
    input  logic          pw_en,
    input  logic [IW-1:0] pw_idx,
    input  logic          sw_en,
    output logic          busy,
    output logic          done,
    output logic          mul_issue,
    output logic [IW-1:0] mul_idx,
    output logic          add_issue,
    output logic [IW-1:0] add_idx
);
    logic          busy_q, done_q, chain_q;
    logic [LW-1:0] vl_q, mul_cnt, add_cnt, prod_cnt, sum_cnt;
    logic [MVL-1:0] ready_q;
    logic          all_prod, finish;
    logic [LW-1:0] vl_eff;

    assign vl_eff    = (vl > LW'(MVL)) ? LW'(MVL) : vl;
    assign all_prod  = (prod_cnt == vl_q);
    assign finish    = busy_q && (sum_cnt == vl_q);
    assign mul_issue = busy_q && (mul_cnt < vl_q);
    assign mul_idx   = mul_cnt[IW-1:0];
    assign add_idx   = add_cnt[IW-1:0];
    assign add_issue = busy_q && (add_cnt < vl_q) && ready_q[add_idx]
                       && (chain_q || all_prod);

    // Command latch, element counters, readiness bits and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            chain_q  <= 1'b0;
            vl_q     <= '0;
            mul_cnt  <= '0;
            add_cnt  <= '0;
            prod_cnt <= '0;
            sum_cnt  <= '0;
            ready_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q   <= 1'b1;
                    vl_q     <= vl_eff;
                    chain_q  <= chain_en;
                    mul_cnt  <= '0;
                    add_cnt  <= '0;
                    prod_cnt <= '0;
                    sum_cnt  <= '0;
                    ready_q  <= '0;
                end
            end else begin
                if (mul_issue) mul_cnt <= mul_cnt + 1'b1;
                if (add_issue) add_cnt <= add_cnt + 1'b1;
                if (pw_en) begin
                    prod_cnt        <= prod_cnt + 1'b1;
                    ready_q[pw_idx] <= 1'b1;
                end
                if (sw_en) sum_cnt <= sum_cnt + 1'b1;
                if (finish) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;

    // R11: completion is a single-cycle pulse and never overlaps busy.
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R3: products come out of the multiplier in element order.
    assert_prod_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pw_en |-> (pw_idx == prod_cnt[IW-1:0]));
    // R6: a sum is never written for an element whose product is missing.
    assert_no_stale_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en |-> (prod_cnt > sum_cnt));
    // R7: without chaining, sums appear only after every product.
    assert_unchained_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && !chain_q) |-> (prod_cnt == vl_q));
    // R10: a start while busy leaves the running command untouched.
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start) |=> ($stable(vl_q) && $stable(chain_q)));
    // R9: the latched length never exceeds the capacity.
    assert_vl_clamped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (vl_q <= LW'(MVL)));
endmodule

// File: rtl/vchain_top.sv
// Chained vector multiply-add pair: product = A*B (6 stages), then
// sum = product + addsrc (2 stages) over a shared length, with optional
// per-element chaining. Test port loads and reads storage; loads are
// ignored while busy.
module vchain_top #(
    parameter int unsigned DW         = 32,
    parameter int unsigned MVL        = 32,
    parameter int unsigned MUL_STAGES = 6,
    parameter int unsigned ADD_STAGES = 2,
    localparam int unsigned IW        = $clog2(MVL),
    localparam int unsigned LW        = $clog2(MVL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [LW-1:0] vl_i,
    input  logic          chain_en_i,
    input  logic          ld_en_i,
    input  logic [2:0]    ld_sel_i,
    input  logic [IW-1:0] ld_idx_i,
    input  logic [DW-1:0] ld_data_i,
    input  logic [2:0]    rd_sel_i,
    input  logic [IW-1:0] rd_idx_i,
    output logic [DW-1:0] rd_data_o,
    output logic          busy_o,
    output logic          done_o
);
    logic          busy, mul_issue, add_issue;
    logic [IW-1:0] mul_idx, add_idx;
    logic [DW-1:0] mul_a, mul_b, add_p, add_b;
    logic          pw_en, sw_en;
    logic [IW-1:0] pw_idx, sw_idx;
    logic [DW-1:0] pw_data, sw_data;

    vchain_seq #(.MVL(MVL), .IW(IW), .LW(LW)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start_i), .vl(vl_i),
        .chain_en(chain_en_i), .pw_en(pw_en), .pw_idx(pw_idx), .sw_en(sw_en),
        .busy(busy), .done(done_o), .mul_issue(mul_issue), .mul_idx(mul_idx),
        .add_issue(add_issue), .add_idx(add_idx)
    );

    vchain_vrf #(.DW(DW), .MVL(MVL), .IW(IW)) vrf_i (
        .clk(clk), .ld_we(ld_en_i && !busy), .ld_sel(ld_sel_i),
        .ld_idx(ld_idx_i), .ld_data(ld_data_i),
        .pw_en(pw_en), .pw_idx(pw_idx), .pw_data(pw_data),
        .sw_en(sw_en), .sw_idx(sw_idx), .sw_data(sw_data),
        .mul_idx(mul_idx), .mul_a(mul_a), .mul_b(mul_b),
        .add_idx(add_idx), .add_p(add_p), .add_b(add_b),
        .rd_sel(rd_sel_i), .rd_idx(rd_idx_i), .rd_data(rd_data_o)
    );

    vchain_pipe #(.DW(DW), .IW(IW), .STAGES(MUL_STAGES), .MULT(1'b1)) mul_i (
        .clk(clk), .rst_n(rst_n), .in_valid(mul_issue), .in_idx(mul_idx),
        .in_x(mul_a), .in_y(mul_b),
        .out_valid(pw_en), .out_idx(pw_idx), .out_data(pw_data)
    );

    vchain_pipe #(.DW(DW), .IW(IW), .STAGES(ADD_STAGES), .MULT(1'b0)) add_i (
        .clk(clk), .rst_n(rst_n), .in_valid(add_issue), .in_idx(add_idx),
        .in_x(add_p), .in_y(add_b),
        .out_valid(sw_en), .out_idx(sw_idx), .out_data(sw_data)
    );

    assign busy_o = busy;

    // R5: unit writes stay inside the active window.
    assert_writes_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_en || sw_en) |-> busy);
endmodule

// File: tb/vchain_top_tb_top.sv
module vchain_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  vl_i = '0;
    logic        chain_en_i = 1'b0;
    logic        ld_en_i = 1'b0;
    logic [2:0]  ld_sel_i = '0;
    logic [4:0]  ld_idx_i = '0;
    logic [31:0] ld_data_i = '0;
    logic [2:0]  rd_sel_i = '0;
    logic [4:0]  rd_idx_i = '0;
    logic [31:0] rd_data_o;
    logic        busy_o, done_o;

    int total = 0;
    int bad = 0;
    logic [31:0] ma [32];
    logic [31:0] mb [32];
    logic [31:0] ad [32];
    logic [31:0] pp [32];
    logic [31:0] ss [32];

    always #5 clk = ~clk;

    vchain_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
        .chain_en_i(chain_en_i), .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i),
        .ld_idx_i(ld_idx_i), .ld_data_i(ld_data_i), .rd_sel_i(rd_sel_i),
        .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o), .busy_o(busy_o),
        .done_o(done_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [4:0] idx, input logic [31:0] d);
        @(negedge clk);
        ld_en_i = 1'b1; ld_sel_i = sel; ld_idx_i = idx; ld_data_i = d;
        @(negedge clk);
        ld_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, input logic [4:0] idx, output logic [31:0] v);
        @(negedge clk);
        rd_sel_i = sel; rd_idx_i = idx;
        #1 v = rd_data_o;
    endtask

    function automatic logic [31:0] pat(input int seed, input int i, input int kind);
        return 32'(seed * 32'h9E3779B1 + i * (kind + 3) * 32'h01000193 + kind * 32'h7F4A7C15);
    endfunction

    // Reload every vector with fresh patterns and mirror them in the model.
    task automatic load_all(input int seed);
        for (int i = 0; i < 32; i++) begin
            ma[i] = pat(seed, i, 1); mb[i] = pat(seed, i, 2); ad[i] = pat(seed, i, 3);
            pp[i] = pat(seed, i, 4); ss[i] = pat(seed, i, 5);
            wr(3'd1, 5'(i), ma[i]); wr(3'd2, 5'(i), mb[i]); wr(3'd4, 5'(i), ad[i]);
            wr(3'd0, 5'(i), pp[i]); wr(3'd3, 5'(i), ss[i]);
        end
    endtask

    // One command: timing check, optional busy interference, then readback.
    task automatic run(input int vl, input bit chain, input bit interfere);
        int ve, expk, k;
        bit got;
        logic [31:0] v, s0_old;
        ve = (vl > 32) ? 32 : vl;
        expk = (ve == 0) ? 1 : (chain ? ve + 8 : 2 * ve + 7);
        s0_old = ss[0];
        @(negedge clk);
        vl_i = 6'(vl); chain_en_i = chain; start_i = 1'b1;
        rd_sel_i = 3'd3; rd_idx_i = 5'd0;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        k = 0; got = 0;
        while (!got && k < 300) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            #1;
            if (k == 3 && interfere) begin
                start_i = 1'b1; vl_i = 6'd5; chain_en_i = !chain;
                ld_en_i = 1'b1; ld_sel_i = 3'd4; ld_idx_i = 5'd0; ld_data_i = 32'hDEAD_BEEF;
            end
            if (k == 4 && interfere) begin
                start_i = 1'b0; ld_en_i = 1'b0;
            end
            if (k == 8 && ve == 32) // R12: element-level forwarding visible mid-run
                chk("R12 sum[0] at edge 8", rd_data_o,
                    chain ? (ma[0] * mb[0] + ad[0]) : s0_old);
            if (done_o) got = 1;
            else if (k == 1) chk("R11 busy after start", {31'b0, busy_o}, 32'd1);
        end
        chk(ve == 0 ? "R8 done latency" : (chain ? "R6 done latency" : "R7 done latency"),
            32'(k), 32'(expk));
        chk("R11 busy low at done", {31'b0, busy_o}, 32'd0);
        @(negedge clk);
        chk("R11 done one cycle", {31'b0, done_o}, 32'd0);
        for (int i = 0; i < ve; i++) begin
            pp[i] = ma[i] * mb[i];
            ss[i] = pp[i] + ad[i];
        end
        for (int i = 0; i < 32; i++) begin
            rd(3'd0, 5'(i), v);
            chk(i < ve ? "R3 product" : "R5 product kept", v, pp[i]);
            rd(3'd3, 5'(i), v);
            chk(i < ve ? "R4 sum" : "R5 sum kept", v, ss[i]);
        end
        if (interfere) begin
            rd(3'd4, 5'd0, v);
            chk("R10 load while busy ignored", v, ad[0]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 busy at reset", {31'b0, busy_o}, 32'd0);
        chk("R1 done at reset", {31'b0, done_o}, 32'd0);
        rst_n = 1'b1;
        // R2: load, read back, unused selects
        load_all(1);
        for (int i = 0; i < 32; i += 7) begin
            rd(3'd1, 5'(i), v); chk("R2 readback A", v, ma[i]);
            rd(3'd4, 5'(i), v); chk("R2 readback addsrc", v, ad[i]);
        end
        wr(3'd6, 5'd0, 32'h1234_5678);
        for (int s = 0; s < 5; s++) begin
            rd(3'(s), 5'd0, v);
            chk("R2 write to unused select", v,
                s == 0 ? pp[0] : s == 1 ? ma[0] : s == 2 ? mb[0] : s == 3 ? ss[0] : ad[0]);
        end
        rd(3'd6, 5'd0, v); chk("R2 unused select reads zero", v, 32'd0);
        // R6 R7 R8 R9 sweep over all lengths and both modes
        for (int l = 0; l <= 34; l++) begin
            for (int c = 0; c < 2; c++) begin
                load_all(l * 2 + c + 10);
                run(l, c[0], 1'b0);
            end
        end
        // R10: start and load during a running command
        load_all(99);
        run(20, 1'b1, 1'b1);
        load_all(100);
        run(20, 1'b0, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule